// File: doc/BRIEF.md
# Active-Matrix LCD Pixel Output Stage

This block drives the pins of an active-matrix LCD panel. It takes pixels from a valid/ready pixel source, which stands in for the output FIFO. It produces five outputs: a free-running pixel clock, a data-enable, horizontal and vertical sync, and a 16-bit pixel data bus. Line and frame geometry come in on configuration inputs: sync width, back porch, active count and front porch, for each axis. All positions advance once per pixel clock period.

When the pixel source has no pixel ready during an active slot, the block does not stall the panel. The bus repeats its last value, data-enable stays high and the pixel clock keeps running. The block counts each missing pixel. At the end of the active region it adds extra enabled slots until the line's full pixel count has gone out, and only then starts the front porch and the next HSYNC. A late source therefore corrupts one line and leaves the next line aligned. A sticky flag records that an underrun happened. Software clears it with a write-one-to-clear pulse.

The bus can be 4, 8 or 16 bits wide. It can also be split into two lanes for dual-panel displays, with separate upper and lower pixel inputs.

Top module: `lcd_active_out`

## Requirements
- R1: While `en_i` is high the pixel clock toggles on every system clock cycle, so one pixel period is two cycles. While `en_i` is low it rests at the level of `pclk_pol_i`.
- R2: Every change of `de_o`, the sync outputs or `data_o` happens at the launch edge of the pixel clock. The launch edge is the rising edge when `pclk_pol_i`=0 and the falling edge when `pclk_pol_i`=1.
- R3: Each line is HSYNC for `h_sync_i` slots, then `h_back_i` slots of back porch, then `h_act_i` active slots, then any stretch slots, then `h_front_i` slots of front porch. `de_o` is high only in active and stretch slots of active lines, and never together with an asserted HSYNC.
- R4: Each frame is `v_sync_i` lines with VSYNC asserted, then `v_back_i`, `v_act_i` and `v_front_i` lines. `de_o` stays low on every line outside the `v_act_i` group and never rises while VSYNC is asserted.
- R5: In an enabled slot where no pixel is offered, `de_o` stays high and `data_o` repeats its previous value.
- R6: An active line with k underrun slots has exactly `h_act_i`+k enabled slots. It delivers exactly `h_act_i` pixels in source order before HSYNC asserts again.
- R7: `urun_flag_o` rises one cycle after the first underrun slot and stays high until a `urun_clr_i` pulse. If a clear and an underrun fall in the same cycle, the flag stays set.
- R8: `bus_mode_i` selects how `pix_upper_i` (U) and `pix_lower_i` (L) fill `data_o`. The codes are:
  - 0: {12'b0, U[3:0]}
  - 1: {8'b0, U[7:0]}
  - 2: U[15:0]
  - 3 (monochrome dual): {8'b0, L[3:0], U[3:0]}
  - 4 (colour dual): {L[7:0], U[7:0]}
  - codes 5 to 7 behave as 2.
- R9: `data_o` changes only when a pixel is accepted. It holds its last value through blanking and while the block is disabled.
- R10: `hs_pol_i`=1 and `vs_pol_i`=1 invert HSYNC and VSYNC, so each then idles high.
- R11: After reset, `de_o`, `data_o`, `urun_flag_o` and the raw sync and pixel-clock levels are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low parks timing at frame start |
| pclk_pol_i | input | 1 | Pixel clock launch-edge select |
| hs_pol_i | input | 1 | HSYNC inversion |
| vs_pol_i | input | 1 | VSYNC inversion |
| bus_mode_i | input | 3 | Bus width / lane mapping code |
| h_sync_i | input | CNT_W | HSYNC width in slots (at least 1) |
| h_back_i | input | CNT_W | Horizontal back porch in slots (at least 1) |
| h_act_i | input | CNT_W | Pixels per line (at least 1) |
| h_front_i | input | CNT_W | Horizontal front porch in slots (at least 1) |
| v_sync_i | input | CNT_W | VSYNC width in lines (at least 1) |
| v_back_i | input | CNT_W | Vertical back porch in lines (at least 1) |
| v_act_i | input | CNT_W | Active lines per frame (at least 1) |
| v_front_i | input | CNT_W | Vertical front porch in lines (at least 1) |
| pix_valid_i | input | 1 | Pixel source has a pixel |
| pix_ready_o | output | 1 | Block takes the offered pixel at this clock edge |
| pix_upper_i | input | 16 | Pixel for single panel or upper panel |
| pix_lower_i | input | 16 | Pixel for lower panel |
| urun_clr_i | input | 1 | Write-one-to-clear for the underrun flag |
| pclk_o | output | 1 | Pixel clock |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| data_o | output | 16 | Pixel data bus |
| urun_flag_o | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with `CNT_W`=6. It programs a ten-slot line (2 sync, 2 back porch, 4 active, 2 front porch) and a six-line frame, so a whole frame takes 120 cycles. With that geometry every porch transition, every stretch length and every vertical phase comes up many times in a short run. Underruns are injected both mid-line and on the last active slot, so stretches of two and three slots are checked against the source order. Every lane-mapping code and the inverted polarities also run for whole frames.

// File: rtl/lcd_pix_pkg.sv
package lcd_pix_pkg;

    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        H_SYNC    = 3'd0,
        H_BACK    = 3'd1,
        H_ACT     = 3'd2,
        H_STRETCH = 3'd3,
        H_FRONT   = 3'd4
    } hphase_e;

    typedef enum logic [1:0] {
        V_SYNC  = 2'd0,
        V_BACK  = 2'd1,
        V_ACT   = 2'd2,
        V_FRONT = 2'd3
    } vphase_e;

    typedef enum logic [2:0] {
        BUS_4      = 3'd0,
        BUS_8      = 3'd1,
        BUS_16     = 3'd2,
        DUAL_MONO  = 3'd3,
        DUAL_COLOR = 3'd4
    } bus_mode_e;

endpackage

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic pol_i,
    output logic step_o,
    output logic pclk_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = en_i ? ~phase_q : 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) phase_q <= 1'b0;
        else       phase_q <= phase_d;
    end

    // a step edge is the one that moves phase 0 -> 1, i.e. the launch edge
    assign step_o = en_i & ~phase_q;
    assign pclk_o = phase_q ^ pol_i;
endmodule

// File: rtl/lcd_lane_map.sv
module lcd_lane_map
    import lcd_pix_pkg::*;
(
    input  logic [2:0]       mode_i,
    input  logic [BUS_W-1:0] upper_i,
    input  logic [BUS_W-1:0] lower_i,
    output logic [BUS_W-1:0] bus_o
);
    localparam int NIB  = BUS_W / 4;
    localparam int HALF = BUS_W / 2;

    always_comb begin
        case (mode_i)
            BUS_4:      bus_o = {{(BUS_W-NIB){1'b0}}, upper_i[NIB-1:0]};
            BUS_8:      bus_o = {{HALF{1'b0}}, upper_i[HALF-1:0]};
            DUAL_MONO:  bus_o = {{HALF{1'b0}}, lower_i[NIB-1:0], upper_i[NIB-1:0]};
            DUAL_COLOR: bus_o = {lower_i[HALF-1:0], upper_i[HALF-1:0]};
            default:    bus_o = upper_i;
        endcase
    end
endmodule

// File: rtl/lcd_active_out.sv
module lcd_active_out
    import lcd_pix_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             pclk_pol_i,
    input  logic             hs_pol_i,
    input  logic             vs_pol_i,
    input  logic [2:0]       bus_mode_i,
    input  logic [CNT_W-1:0] h_sync_i,
    input  logic [CNT_W-1:0] h_back_i,
    input  logic [CNT_W-1:0] h_act_i,
    input  logic [CNT_W-1:0] h_front_i,
    input  logic [CNT_W-1:0] v_sync_i,
    input  logic [CNT_W-1:0] v_back_i,
    input  logic [CNT_W-1:0] v_act_i,
    input  logic [CNT_W-1:0] v_front_i,
    input  logic             pix_valid_i,
    output logic             pix_ready_o,
    input  logic [BUS_W-1:0] pix_upper_i,
    input  logic [BUS_W-1:0] pix_lower_i,
    input  logic             urun_clr_i,
    output logic             pclk_o,
    output logic             de_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic [BUS_W-1:0] data_o,
    output logic             urun_flag_o
);
    typedef struct packed {
        hphase_e          hph;
        vphase_e          vph;
        logic [CNT_W-1:0] hc;
        logic [CNT_W-1:0] vc;
        logic [CNT_W-1:0] miss;
        logic             de;
        logic             hsy;
        logic             vsy;
        logic             flag;
        logic [BUS_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;
    logic step, slot_on, xfer, starve, line_end;
    logic [BUS_W-1:0] mapped;

    function automatic logic at_end(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] len);
        return cnt == len - CNT_W'(1);
    endfunction

    lcd_pclk_gen u_pclk (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .pol_i  (pclk_pol_i),
        .step_o (step),
        .pclk_o (pclk_o)
    );

    lcd_lane_map u_map (
        .mode_i  (bus_mode_i),
        .upper_i (pix_upper_i),
        .lower_i (pix_lower_i),
        .bus_o   (mapped)
    );

    assign slot_on     = (st_q.vph == V_ACT) &&
                         (st_q.hph == H_ACT || st_q.hph == H_STRETCH);
    assign pix_ready_o = step && slot_on;
    assign xfer        = pix_ready_o && pix_valid_i;
    assign starve      = pix_ready_o && !pix_valid_i;

    always_comb begin
        st_d     = st_q;
        line_end = 1'b0;

        if (urun_clr_i) st_d.flag = 1'b0;
        if (starve)     st_d.flag = 1'b1;

        if (!en_i) begin
            st_d.hph  = H_SYNC;
            st_d.vph  = V_SYNC;
            st_d.hc   = '0;
            st_d.vc   = '0;
            st_d.miss = '0;
            st_d.de   = 1'b0;
            st_d.hsy  = 1'b0;
            st_d.vsy  = 1'b0;
        end else if (step) begin
            st_d.de  = slot_on;
            st_d.hsy = (st_q.hph == H_SYNC);
            st_d.vsy = (st_q.vph == V_SYNC);
            if (xfer) st_d.data = mapped;
            st_d.hc = st_q.hc + CNT_W'(1);

            case (st_q.hph)
                H_SYNC: if (at_end(st_q.hc, h_sync_i)) begin
                    st_d.hph = H_BACK;
                    st_d.hc  = '0;
                end
                H_BACK: if (at_end(st_q.hc, h_back_i)) begin
                    st_d.hph = H_ACT;
                    st_d.hc  = '0;
                end
                H_ACT: begin
                    if (starve) st_d.miss = st_q.miss + CNT_W'(1);
                    if (at_end(st_q.hc, h_act_i)) begin
                        st_d.hc  = '0;
                        st_d.hph = (st_d.miss != '0) ? H_STRETCH : H_FRONT;
                    end
                end
                H_STRETCH: begin
                    st_d.hc = '0;
                    if (xfer) begin
                        st_d.miss = st_q.miss - CNT_W'(1);
                        if (st_q.miss == CNT_W'(1)) st_d.hph = H_FRONT;
                    end
                end
                default: if (at_end(st_q.hc, h_front_i)) begin
                    st_d.hph = H_SYNC;
                    st_d.hc  = '0;
                    line_end = 1'b1;
                end
            endcase

            if (line_end) begin
                st_d.vc = st_q.vc + CNT_W'(1);
                case (st_q.vph)
                    V_SYNC: if (at_end(st_q.vc, v_sync_i)) begin
                        st_d.vph = V_BACK;
                        st_d.vc  = '0;
                    end
                    V_BACK: if (at_end(st_q.vc, v_back_i)) begin
                        st_d.vph = V_ACT;
                        st_d.vc  = '0;
                    end
                    V_ACT: if (at_end(st_q.vc, v_act_i)) begin
                        st_d.vph = V_FRONT;
                        st_d.vc  = '0;
                    end
                    default: if (at_end(st_q.vc, v_front_i)) begin
                        st_d.vph = V_SYNC;
                        st_d.vc  = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign de_o        = st_q.de;
    assign hsync_o     = st_q.hsy ^ hs_pol_i;
    assign vsync_o     = st_q.vsy ^ vs_pol_i;
    assign data_o      = st_q.data;
    assign urun_flag_o = st_q.flag;
endmodule

// File: rtl/lcd_active_out_chk.sv
module lcd_active_out_chk
    import lcd_pix_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic             pclk_pol_i,
    input logic             hs_pol_i,
    input logic             vs_pol_i,
    input logic             pix_valid_i,
    input logic             pix_ready_o,
    input logic             urun_clr_i,
    input logic             pclk_o,
    input logic             de_o,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic [BUS_W-1:0] data_o,
    input logic             urun_flag_o
);
    // R1
    pclk_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && $past(en_i) && !$past(rst_i) && $stable(pclk_pol_i))
            |-> (pclk_o != $past(pclk_o)));

    // R3
    hsync_de_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !((hsync_o ^ hs_pol_i) && de_o));

    // R4
    vsync_de_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !((vsync_o ^ vs_pol_i) && de_o));

    // R5
    starve_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pix_ready_o && !pix_valid_i && de_o) |=> (de_o && $stable(data_o)));

    // R7
    flag_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pix_ready_o && !pix_valid_i) |=> urun_flag_o);

    // R7
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (urun_clr_i && !(pix_ready_o && !pix_valid_i)) |=> !urun_flag_o);

    // R9
    data_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pix_ready_o && pix_valid_i) |=> $stable(data_o));
endmodule

bind lcd_active_out lcd_active_out_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .en_i        (en_i),
    .pclk_pol_i  (pclk_pol_i),
    .hs_pol_i    (hs_pol_i),
    .vs_pol_i    (vs_pol_i),
    .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o),
    .urun_clr_i  (urun_clr_i),
    .pclk_o      (pclk_o),
    .de_o        (de_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .data_o      (data_o),
    .urun_flag_o (urun_flag_o)
);

// File: tb/lcd_active_out_bench.sv
module lcd_active_out_bench;
    import lcd_pix_pkg::*;

    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic pclk_pol = 1'b0, hs_pol = 1'b0, vs_pol = 1'b0;
    logic [2:0] mode = 3'd2;
    logic [CW-1:0] h_sync = 6'd2, h_back = 6'd2, h_act = 6'd4, h_front = 6'd2;
    logic [CW-1:0] v_sync = 6'd1, v_back = 6'd1, v_act = 6'd3, v_front = 6'd1;
    logic pix_valid = 1'b1;
    logic pix_ready;
    logic [15:0] up, lo;
    logic clr = 1'b0;
    logic pclk, de, hsync, vsync, flag;
    logic [15:0] data;

    lcd_active_out #(.CNT_W(CW)) u_lcd_active_out (
        .clk_i(clk), .rst_i(rst), .en_i(en),
        .pclk_pol_i(pclk_pol), .hs_pol_i(hs_pol), .vs_pol_i(vs_pol),
        .bus_mode_i(mode),
        .h_sync_i(h_sync), .h_back_i(h_back), .h_act_i(h_act), .h_front_i(h_front),
        .v_sync_i(v_sync), .v_back_i(v_back), .v_act_i(v_act), .v_front_i(v_front),
        .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
        .pix_upper_i(up), .pix_lower_i(lo), .urun_clr_i(clr),
        .pclk_o(pclk), .de_o(de), .hsync_o(hsync), .vsync_o(vsync),
        .data_o(data), .urun_flag_o(flag)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [15:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_map(input logic [2:0] m, input logic [15:0] u,
                                            input logic [15:0] l);
        case (m)
            3'd0: ref_map = {12'h0, u[3:0]};
            3'd1: ref_map = {8'h0, u[7:0]};
            3'd3: ref_map = {8'h0, l[3:0], u[3:0]};
            3'd4: ref_map = {l[7:0], u[7:0]};
            default: ref_map = u;
        endcase
    endfunction

    // pixel source and scoreboard driver
    int seq = 0, stall_req = 0, stall_used = 0;
    bit prev_ready = 0, prev_xfer = 0;
    assign up = 16'h1000 + 16'(seq * 16'h0123);
    assign lo = 16'hA5C0 ^ 16'(seq * 16'h0101);

    task automatic drive_slot();
        if (prev_ready) begin
            if (prev_xfer) seq++;
            if (stall_used < stall_req) begin
                pix_valid = 1'b0;
                stall_used++;
            end else pix_valid = 1'b1;
        end
        prev_ready = pix_ready;
        prev_xfer  = pix_ready && pix_valid;
        if (prev_xfer) exp_q.push_back(ref_map(mode, up, lo));
    endtask

    // monitor
    logic pclk_prev = 1'b0, hs_prev = 1'b0, vs_prev = 1'b0, de_prev = 1'b0;
    logic [15:0] last_data = '0, data_prev = '0;
    int de_line = 0, line_idx = 0, frames = 0, hs_run = 0, hs_width = 0;
    int vs_run = 0, vs_width = 0;
    int de_of_line[8];

    always @(negedge clk) begin
        if (!rst) begin
            // R2: outputs move only at the launch edge
            if (en && (data !== data_prev || de !== de_prev))
                chk(((pclk ^ pclk_pol) == 1'b1) && (pclk != pclk_prev),
                    "R2 launch edge", pclk, ~pclk_pol);
            if (en && ((pclk ^ pclk_pol) == 1'b1) && ((pclk_prev ^ pclk_pol) == 1'b0)) begin
                if (de) begin
                    de_line++;
                    chk(hsync == hs_pol && vsync == vs_pol, "R10 sync idle level",
                        {hsync, vsync}, {hs_pol, vs_pol});
                    if (prev_xfer) begin
                        if (exp_q.size() == 0) chk(0, "R6 unexpected pixel", data, 0);
                        else begin
                            logic [15:0] e;
                            e = exp_q.pop_front();
                            chk(data == e, "R8 pixel", data, e);
                        end
                    end else chk(data == last_data, "R5 repeat on underrun", data, last_data);
                end else chk(data == last_data, "R9 hold in blanking", data, last_data);
                if ((hsync ^ hs_pol) && !hs_prev) begin
                    if (line_idx < 8) de_of_line[line_idx] = de_line;
                    de_line = 0;
                    if ((vsync ^ vs_pol) && !vs_prev) begin
                        frames++;
                        line_idx = 0;
                    end else line_idx++;
                end
                if (hsync ^ hs_pol) hs_run++;
                else begin
                    if (hs_prev) hs_width = hs_run;
                    hs_run = 0;
                end
                if (vsync ^ vs_pol) vs_run++;
                else begin
                    if (vs_prev) vs_width = vs_run;
                    vs_run = 0;
                end
                hs_prev   = hsync ^ hs_pol;
                vs_prev   = vsync ^ vs_pol;
                last_data = data;
            end
            drive_slot();
        end
        pclk_prev = pclk;
        de_prev   = de;
        data_prev = data;
    end

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        wait (frames >= target);
        @(posedge clk); #1;
    endtask

    task automatic check_lines(input string tag, input int a2, input int a3, input int a4);
        chk(de_of_line[0] == 0 && de_of_line[1] == 0 && de_of_line[5] == 0,
            {tag, " blank lines"}, de_of_line[1], 0);
        chk(de_of_line[2] == a2, {tag, " line2"}, de_of_line[2], a2);
        chk(de_of_line[3] == a3, {tag, " line3"}, de_of_line[3], a3);
        chk(de_of_line[4] == a4, {tag, " line4"}, de_of_line[4], a4);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11
        chk(de == 0 && data == 0 && flag == 0 && hsync == 0 && vsync == 0,
            "R11 reset state", {de, flag, hsync, vsync}, 0);
        // R1 idle
        chk(pclk == pclk_pol, "R1 idle level", pclk, pclk_pol);

        @(posedge clk); #1 en = 1'b1;
        begin
            int tog;
            tog = 0;
            @(negedge clk);
            for (int i = 0; i < 20; i++) begin
                logic p;
                p = pclk;
                @(negedge clk);
                if (pclk != p) tog++;
            end
            chk(tog == 20, "R1 toggles per cycle", tog, 20);
        end

        wait_frames(3);
        // R3 / R4 geometry
        check_lines("R3 plain frame", 4, 4, 4);
        chk(hs_width == 2, "R3 hsync width", hs_width, 2);
        chk(vs_width == 10, "R4 vsync width", vs_width, 10);
        chk(flag == 0, "R7 no flag without underrun", flag, 0);

        // R6 underrun mid-line and at the line end
        wait (line_idx == 3);
        @(posedge clk); #1 stall_req += 2;
        wait (line_idx == 4);
        @(posedge clk); #1 stall_req += 3;
        wait_frames(1);
        check_lines("R6 stretched", 4, 6, 7);
        chk(exp_q.size() <= 1, "R6 all pixels drained", exp_q.size(), 0);
        chk(flag == 1, "R7 flag set", flag, 1);
        wait_frames(1);
        chk(flag == 1, "R7 flag sticky", flag, 1);
        check_lines("R6 next frame clean", 4, 4, 4);

        @(posedge clk); #1 clr = 1'b1;
        @(posedge clk); #1 clr = 1'b0;
        @(negedge clk);
        chk(flag == 0, "R7 flag cleared", flag, 0);

        // R8 each lane mapping code for a full frame
        foreach (exp_q[i]) begin end
        for (int m = 0; m < 6; m++) begin
            wait (line_idx == 5);
            @(posedge clk); #1 mode = 3'(m);
            wait_frames(2);
            check_lines("R8 mode frame", 4, 4, 4);
        end

        // R10 / R1 / R2 with inverted polarities
        @(posedge clk); #1 en = 1'b0;
        repeat (3) @(posedge clk);
        #1 pclk_pol = 1'b1; hs_pol = 1'b1; vs_pol = 1'b1;
        @(negedge clk);
        chk(pclk == 1'b1, "R1 idle inverted", pclk, 1);
        chk(hsync == 1'b1 && vsync == 1'b1, "R10 inverted idle", {hsync, vsync}, 3);
        chk(data == last_data, "R9 hold while disabled", data, last_data);
        @(posedge clk); #1 en = 1'b1;
        wait_frames(3);
        check_lines("R10 inverted frame", 4, 4, 4);
        chk(hs_width == 2, "R10 hsync width inverted", hs_width, 2);
        wait (line_idx == 2);
        @(posedge clk); #1 stall_req += 1;
        wait_frames(1);
        check_lines("R5 underrun inverted", 5, 4, 4);
        finish_run();
    end
endmodule